// File: doc/BRIEF.md
# TDM Input Stream Frame Aligner

This block takes one serial time-division-multiplexed input line, a master frame pulse and a sampling clock that runs at four times the line bit rate. It cuts the line into bytes and labels each byte with a logical channel number, so that the stream can have its own frame alignment relative to the common frame pulse. Each recovered byte is presented with its channel number and a one-cycle valid strobe, ready to be written into a switching store by the logic that follows.

Alignment has two parts. A whole-channel delay picks which physical slot after the frame boundary is called channel 0. A fractional bit delay then moves the sampling instant later in quarter-bit steps, up to 7.75 bits. Together they can put channel 0 anywhere in the frame with quarter-bit resolution. Two line rates are supported: 128 channels per frame or 256 channels per frame. Each frame has 8-bit channels, and at both rates the sampling clock is four times the bit rate.

Delay and rate settings arrive on plain configuration inputs. They are taken in only at a frame pulse, so a frame is never received with mixed alignment. If a frame pulse comes early or late, the internal timing restarts from it.

Top module: `tdm_frame_aligner`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rx_valid`, `rx_data` and `rx_chan` are zero, the active rate is the 128-channel rate and both active delays are zero. `rx_valid` stays low until the first frame pulse has been seen.
- R2: Edge 0 is the rising edge at which `frm_pulse` is sampled high, and D is `cfg_bit_dly` (0 to 31, in quarter bits). `ser_in` is sampled at edge 2+D and then at every fourth edge after it.
- R3: Each byte is built from eight consecutive samples, most significant bit first. The first sample of a byte ends up in `rx_data[7]`.
- R4: `rx_valid` is high for exactly one cycle, the cycle after the edge that captures the eighth sample of a slot. `rx_data` and `rx_chan` change only when `rx_valid` goes high, and they hold otherwise.
- R5: Sample index k (counted from the first sample after edge 0) falls in physical slot s = floor(k/8). That slot is reported as channel (s - C) mod N, where C is the channel delay and N is the number of channels. For example, with C = 1 at the 128-channel rate, slot 0 is reported as channel 127.
- R6: When `cfg_rate` = 0, a frame has 128 channels (4096 clock edges) and only the low 7 bits of `cfg_chan_dly` are used. When `cfg_rate` = 1, a frame has 256 channels (8192 edges) and all 8 bits are used.
- R7: `cfg_rate`, `cfg_chan_dly` and `cfg_bit_dly` are captured only at an edge where `frm_pulse` is high. Changes at any other time have no effect until the next pulse.
- R8: A bit delay of 4q+r quarter bits moves every sample by q whole bit periods plus r clock edges. Sample positions that run past the nominal frame length keep counting modulo the frame length.
- R9: A frame pulse that arrives before or after the nominal frame length restarts the timing from that pulse. The frame that follows is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the line bit rate |
| rst | input | 1 | Synchronous active-high reset |
| frm_pulse | input | 1 | Master frame pulse, one clock wide, marks the frame boundary |
| ser_in | input | 1 | Serial TDM input line |
| cfg_rate | input | 1 | 0: 128 channels per frame, 1: 256 channels per frame |
| cfg_chan_dly | input | 8 | Whole-channel delay: the physical slot that becomes channel 0 |
| cfg_bit_dly | input | 5 | Fractional delay, in quarter bits (0 to 31) |
| rx_data | output | 8 | Recovered byte, first received bit in bit 7 |
| rx_chan | output | 8 | Logical channel number of `rx_data` |
| rx_valid | output | 1 | One-cycle strobe marking a new byte |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the data on the line. The strobe is never two cycles wide, and it stays low before the first frame pulse. Byte and channel outputs hold between strobes. Channel numbers stay within range at the low rate. The active settings move only at a pulse. The scenarios are needed for everything that depends on the line contents and the edge count: where each quarter-bit delay lands the sample, how the channel delay relabels slots (including the wrap to the highest channel), how the top delay bit is ignored at the low rate, how a mid-frame change is deferred, and how the timing recovers after an early or late pulse.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

    // Geometry of one input line
    localparam int CHAN_W  = 8;                       // channel number width (max 256 channels)
    localparam int BDLY_W  = 5;                       // fractional delay width, quarter-bit units
    localparam int DATA_W  = 8;                       // bits per channel
    localparam int OVS_LG2 = 2;                       // sampling clock is 2**OVS_LG2 times bit rate
    localparam int BIT_LG2 = $clog2(DATA_W);
    localparam int PH_W    = CHAN_W + BIT_LG2 + OVS_LG2;
    localparam int CENTRE  = 2;                       // default sample tick inside a bit

    typedef enum logic {
        RATE_LO = 1'b0,                               // half the channels
        RATE_HI = 1'b1                                // full channel count
    } rate_e;

    typedef struct packed {
        rate_e               rate;
        logic [CHAN_W-1:0]   cdly;
        logic [BDLY_W-1:0]   bdly;
    } align_cfg_t;

    typedef logic [PH_W-1:0] phase_t;

    // Last tick index of a frame at the given rate
    function automatic phase_t frame_last(rate_e r);
        if (r == RATE_HI)
            return phase_t'((1 << PH_W) - 1);
        return phase_t'((1 << (PH_W - 1)) - 1);
    endfunction

    // Phase loaded at the pulse edge: frame length minus centre minus delay
    function automatic phase_t reload_phase(rate_e r, logic [BDLY_W-1:0] d);
        return frame_last(r) - phase_t'(CENTRE - 1) - phase_t'(d);
    endfunction

    // Channel number mask for the active rate
    function automatic logic [CHAN_W-1:0] chan_mask(rate_e r);
        if (r == RATE_HI)
            return {CHAN_W{1'b1}};
        return {1'b0, {(CHAN_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/tdm_cfg_shadow.sv
module tdm_cfg_shadow
    import tdm_align_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_pulse,
    input  align_cfg_t cfg_in,
    output align_cfg_t cfg_eff,
    output align_cfg_t cfg_act,
    output logic       locked_q,
    output logic       run
);

    // Settings become active only at a frame pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act  <= '0;
            locked_q <= 1'b0;
        end else if (frm_pulse) begin
            cfg_act  <= cfg_in;
            locked_q <= 1'b1;
        end
    end

    // The pulse edge itself already works with the new settings
    always_comb begin
        cfg_eff = frm_pulse ? cfg_in : cfg_act;
        run     = locked_q | frm_pulse;
    end

endmodule

// File: rtl/tdm_phase_ctr.sv
module tdm_phase_ctr
    import tdm_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_pulse,
    input  logic              run,
    input  rate_e             rate,
    input  logic [BDLY_W-1:0] bdly,
    output logic              samp,
    output logic              last_bit,
    output logic [CHAN_W-1:0] slot
);

    phase_t ph_q;
    phase_t ph_d;

    // Phase counts ticks relative to the delayed channel-0 start, modulo frame
    always_comb begin
        if (frm_pulse)
            ph_d = reload_phase(rate, bdly);
        else if (ph_q == frame_last(rate))
            ph_d = '0;
        else
            ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= '0;
        else if (run)
            ph_q <= ph_d;
    end

    always_comb begin
        samp     = run && (ph_d[OVS_LG2-1:0] == '0);
        last_bit = samp && (&ph_d[OVS_LG2 +: BIT_LG2]);
        slot     = ph_d[PH_W-1 -: CHAN_W];
    end

endmodule

// File: rtl/tdm_byte_asm.sv
module tdm_byte_asm
    import tdm_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp,
    input  logic              last_bit,
    input  logic              ser_in,
    input  logic [CHAN_W-1:0] slot,
    input  logic [CHAN_W-1:0] cdly,
    input  rate_e             rate,
    output logic [DATA_W-1:0] rx_data,
    output logic [CHAN_W-1:0] rx_chan,
    output logic              rx_valid
);

    logic [DATA_W-2:0] sh_q;
    logic [DATA_W-1:0] word;
    logic [CHAN_W-1:0] lchan;

    always_comb begin
        word  = {sh_q, ser_in};
        lchan = (slot - cdly) & chan_mask(rate);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            rx_data  <= '0;
            rx_chan  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last_bit;
            if (samp)
                sh_q <= word[DATA_W-2:0];
            if (last_bit) begin
                rx_data <= word;
                rx_chan <= lchan;
            end
        end
    end

endmodule

// File: rtl/tdm_frame_aligner.sv
module tdm_frame_aligner
    import tdm_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_pulse,
    input  logic              ser_in,
    input  logic              cfg_rate,
    input  logic [CHAN_W-1:0] cfg_chan_dly,
    input  logic [BDLY_W-1:0] cfg_bit_dly,
    output logic [DATA_W-1:0] rx_data,
    output logic [CHAN_W-1:0] rx_chan,
    output logic              rx_valid
);

    align_cfg_t        cfg_in_s;
    align_cfg_t        cfg_eff;
    align_cfg_t        cfg_act;
    logic              locked_q;
    logic              run;
    logic              samp;
    logic              last_bit;
    logic [CHAN_W-1:0] slot;

    always_comb begin
        cfg_in_s.rate = rate_e'(cfg_rate);
        cfg_in_s.cdly = cfg_chan_dly;
        cfg_in_s.bdly = cfg_bit_dly;
    end

    tdm_cfg_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .frm_pulse (frm_pulse),
        .cfg_in    (cfg_in_s),
        .cfg_eff   (cfg_eff),
        .cfg_act   (cfg_act),
        .locked_q  (locked_q),
        .run       (run)
    );

    tdm_phase_ctr u_phase (
        .clk       (clk),
        .rst       (rst),
        .frm_pulse (frm_pulse),
        .run       (run),
        .rate      (cfg_eff.rate),
        .bdly      (cfg_eff.bdly),
        .samp      (samp),
        .last_bit  (last_bit),
        .slot      (slot)
    );

    tdm_byte_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .samp      (samp),
        .last_bit  (last_bit),
        .ser_in    (ser_in),
        .slot      (slot),
        .cdly      (cfg_eff.cdly),
        .rate      (cfg_eff.rate),
        .rx_data   (rx_data),
        .rx_chan   (rx_chan),
        .rx_valid  (rx_valid)
    );

endmodule

// File: rtl/tdm_frame_aligner_chk.sv
module tdm_frame_aligner_chk
    import tdm_align_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_pulse,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic [CHAN_W-1:0] rx_chan,
    input logic              locked_q,
    input align_cfg_t        cfg_act
);

    // R1
    no_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !locked_q |-> !rx_valid);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_chan)));

    // R6
    chan_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_act.rate == RATE_LO) |-> !rx_chan[CHAN_W-1]);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_pulse |=> $stable(cfg_act));

endmodule

bind tdm_frame_aligner tdm_frame_aligner_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_pulse (frm_pulse),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_chan   (rx_chan),
    .locked_q  (locked_q),
    .cfg_act   (cfg_act)
);

// File: tb/tdm_frame_aligner_tb.sv
module tdm_frame_aligner_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frm_pulse = 1'b0;
    logic       ser_in = 1'b0;
    logic       cfg_rate = 1'b0;
    logic [7:0] cfg_chan_dly = 8'd0;
    logic [4:0] cfg_bit_dly = 5'd0;
    logic [7:0] rx_data;
    logic [7:0] rx_chan;
    logic       rx_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_frame_aligner u_dut (
        .clk          (clk),
        .rst          (rst),
        .frm_pulse    (frm_pulse),
        .ser_in       (ser_in),
        .cfg_rate     (cfg_rate),
        .cfg_chan_dly (cfg_chan_dly),
        .cfg_bit_dly  (cfg_bit_dly),
        .rx_data      (rx_data),
        .rx_chan      (rx_chan),
        .rx_valid     (rx_valid)
    );

    int errors = 0;
    int checks = 0;
    int vcount = 0;
    bit armed  = 0;
    bit done   = 0;

    // line generator state
    int p_line   = 0;
    int line_nch = 128;

    // behavioural reference
    bit         m_on  = 0;
    int         m_t   = 0;
    int         m_d   = 0;
    int         m_c   = 0;
    int         m_nch = 128;
    logic [7:0] m_sh  = '0;
    logic       e_vld = 1'b0;
    logic [7:0] e_data = '0;
    logic [7:0] e_chan = '0;

    int got [256];

    function automatic logic [7:0] pat(int s);
        return 8'((s * 37 + 11) & 255);
    endfunction

    function automatic logic line_bit(int p, int nch);
        logic [7:0] v;
        v = pat((p / 32) % nch);
        return v[7 - ((p / 4) % 8)];
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_got();
        for (int i = 0; i < 256; i++) got[i] = -1;
    endtask

    task automatic compare();
        chk("R4", int'(rx_valid), int'(e_vld), "strobe");
        if (e_vld) begin
            chk("R3", int'(rx_data), int'(e_data), "byte");
            chk("R5", int'(rx_chan), int'(e_chan), "channel");
        end
        if (rx_valid) begin
            vcount++;
            got[rx_chan] = int'(rx_data);
        end
    endtask

    task automatic model_edge();
        int f;
        int r;
        if (rst) begin
            m_on = 0; m_t = 0; m_sh = '0; m_d = 0; m_c = 0; m_nch = 128;
            e_vld = 1'b0; e_data = '0; e_chan = '0;
            return;
        end
        e_vld = 1'b0;
        if (frm_pulse) begin
            m_on  = 1;
            m_t   = 0;
            m_nch = cfg_rate ? 256 : 128;
            m_d   = int'(cfg_bit_dly);
            m_c   = int'(cfg_chan_dly) % m_nch;
        end else if (m_on) begin
            m_t++;
        end
        if (m_on) begin
            f = m_nch * 32;
            r = (((m_t - 2 - m_d) % f) + f) % f;
            if (r % 4 == 0) begin
                m_sh = {m_sh[6:0], ser_in};
                if ((r / 4) % 8 == 7) begin
                    e_vld  = 1'b1;
                    e_data = m_sh;
                    e_chan = 8'((((r / 32) - m_c) % m_nch + m_nch) % m_nch);
                end
            end
        end
    endtask

    task automatic step(input logic fp);
        if (armed) compare();
        frm_pulse = fp;
        if (fp) begin
            p_line   = 0;
            line_nch = cfg_rate ? 256 : 128;
        end else begin
            p_line++;
        end
        ser_in = line_bit(p_line, line_nch);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        armed = 1;
    endtask

    task automatic run_frame(int n);
        clear_got();
        step(1'b1);
        for (int i = 1; i < n; i++) step(1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    function automatic int pair(int a, int b);
        logic [7:0] x;
        logic [7:0] y;
        x = pat(a);
        y = pat(b);
        return int'({x[5:0], y[7:6]});
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clear_got();
        @(negedge clk);
        idle(5);
        rst = 1'b0;
        // R1: reset values
        chk("R1", int'(rx_valid), 0, "valid after reset");
        chk("R1", int'(rx_data), 0, "data after reset");
        chk("R1", int'(rx_chan), 0, "channel after reset");
        vcount = 0;
        idle(300);
        chk("R1", vcount, 0, "strobes before first pulse");

        // R2 R3: default alignment
        run_frame(4096);
        run_frame(4096);
        chk("R3", got[0], int'(pat(0)), "channel 0 byte");
        chk("R2", got[5], int'(pat(5)), "channel 5 byte");
        chk("R2", got[127], int'(pat(127)), "last channel byte");

        // R5: channel delay 1
        cfg_chan_dly = 8'd1;
        run_frame(4096);
        run_frame(4096);
        chk("R5", got[127], int'(pat(0)), "slot 0 labelled 127");
        chk("R5", got[0], int'(pat(1)), "slot 1 labelled 0");

        // R7: change mid-frame is deferred
        clear_got();
        step(1'b1);
        idle(99);
        cfg_chan_dly = 8'd3;
        idle(3996);
        chk("R7", got[10], int'(pat(11)), "mid-frame change ignored");
        run_frame(4096);
        chk("R7", got[10], int'(pat(13)), "change applied at pulse");

        // R8: fractional delays
        cfg_chan_dly = 8'd0;
        cfg_bit_dly  = 5'd8;
        run_frame(4096);
        chk("R8", got[3], pair(3, 4), "two-bit shift");
        cfg_bit_dly  = 5'd31;
        run_frame(4096);
        chk("R8", got[3], int'(pat(4)), "one-byte shift");
        chk("R8", got[10], int'(pat(11)), "one-byte shift later slot");

        // R6: full rate
        cfg_bit_dly  = 5'd0;
        cfg_rate     = 1'b1;
        cfg_chan_dly = 8'd200;
        run_frame(8192);
        vcount = 0;
        run_frame(8192);
        chk("R6", vcount, 256, "bytes per full-rate frame");
        chk("R6", got[55], int'(pat(255)), "full-rate slot 255");
        chk("R6", got[0], int'(pat(200)), "full-rate slot 200");

        // R6: low rate ignores the top delay bit
        cfg_rate = 1'b0;
        run_frame(4096);
        vcount = 0;
        run_frame(4096);
        chk("R6", vcount, 128, "bytes per low-rate frame");
        chk("R6", got[0], int'(pat(72)), "top delay bit ignored");

        // R9: early then late pulse
        cfg_chan_dly = 8'd0;
        run_frame(1000);
        run_frame(5000);
        run_frame(4096);
        chk("R9", got[7], int'(pat(7)), "after resync channel 7");
        chk("R9", got[100], int'(pat(100)), "after resync channel 100");

        idle(40);
        done = 1;
        summary();
        $finish;
    end

endmodule